// File: doc/BRIEF.md
# Packed SIMD Lane ALU

This block is a 64-bit arithmetic and logic unit that treats both operands as packed vectors of small integers and applies one operation to every element at once. A two-bit lane-size input cuts the datapath at run time into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Carries and borrows never cross from one lane into the next.

The operations are add and subtract with wraparound, add and subtract with unsigned saturation, add and subtract with signed saturation, and bitwise AND, OR and XOR. An input strobe marks a valid operation. The result is captured in a register and shown, with an output strobe, one clock later. Lane 0 holds the least significant bits, and the lanes ascend toward bit 63.

Top module: `simd_alu`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `res_valid` is 0 and `res_data` is all zeros.
- R2: `res_valid` is 1 exactly in the cycle after a clock edge where `in_valid` was 1. `res_data` changes only on such edges and otherwise holds its last value.
- R3: Opcode 0 adds with wraparound in each lane. The lane-size code selects the lanes: 0 gives eight bytes, 1 gives four 16-bit words, 2 gives two 32-bit words, and 3 behaves as 0. No carry enters a lane from the lane below it.
- R4: Opcode 1 subtracts B from A with wraparound in each lane, and no borrow crosses a lane boundary.
- R5: Opcode 2 adds as unsigned numbers per lane, and a lane that overflows becomes all ones.
- R6: Opcode 4 subtracts B from A as unsigned numbers per lane, and a lane that would go below zero becomes zero.
- R7: Opcodes 3 (add) and 5 (subtract) work as two's-complement numbers per lane. A lane that overflows becomes that lane's most positive value (top bit 0, all other bits 1) or its most negative value (top bit 1, all other bits 0), following the sign of the true result.
- R8: Opcodes 6, 7 and 8 give the bitwise AND, OR and XOR of the operands. The lane-size code has no effect on them.
- R9: Opcodes 9 to 15 give an all-zero result.
- R10: Lane n takes bits [n*W+W-1 : n*W] of each operand and of the result, where W is the lane width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe for this cycle |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| op_code | input | 4 | Operation select (see R3 to R9) |
| lane_mode | input | 2 | Lane size: 0 byte, 1 word, 2 doubleword, 3 as byte |
| res_valid | output | 1 | Result strobe, one cycle after in_valid |
| res_data | output | 64 | Registered packed result |

## Verification
Some operand patterns put an all-ones lane beside a +1 lane. These show whether a carry leaks across a boundary, and running them in each lane mode shows whether the mode picks the right cut points. Operands at the signed and unsigned extremes (0x7F, 0x80, 0xFF, 0x00 per lane) separate the four clamping rules from each other and from wraparound. Gaps in the input strobe with changing operands show that the output register holds its value. A long run of random operands, opcodes and modes is then compared against a per-lane integer model on every clock.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int DATA_W   = 64;
    localparam int SLICE_W  = 8;
    localparam int N_SLICE  = DATA_W / SLICE_W;
    localparam int IDX_W    = $clog2(N_SLICE);

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_ADDU_S = 4'd2,
        OP_ADDS_S = 4'd3,
        OP_SUBU_S = 4'd4,
        OP_SUBS_S = 4'd5,
        OP_AND    = 4'd6,
        OP_OR     = 4'd7,
        OP_XOR    = 4'd8
    } opcode_e;

    typedef enum logic [1:0] {
        LM_BYTE  = 2'd0,
        LM_WORD  = 2'd1,
        LM_DWORD = 2'd2,
        LM_RSVD  = 2'd3
    } lane_mode_e;

    typedef enum logic [1:0] {
        CL_NONE = 2'd0,
        CL_UNS  = 2'd1,
        CL_SGN  = 2'd2
    } clamp_e;

    typedef enum logic [1:0] {
        RS_ARITH = 2'd0,
        RS_LOGIC = 2'd1,
        RS_ZERO  = 2'd2
    } res_src_e;

    typedef struct packed {
        logic     is_sub;
        clamp_e   clamp;
        res_src_e src;
        logic [1:0] logic_fn;
    } op_ctl_t;

    typedef struct packed {
        logic             bottom;
        logic             top;
        logic [IDX_W-1:0] top_idx;
    } slice_pos_t;

    function automatic op_ctl_t decode_op(input logic [3:0] code);
        op_ctl_t c;
        c.is_sub   = 1'b0;
        c.clamp    = CL_NONE;
        c.src      = RS_ARITH;
        c.logic_fn = 2'd0;
        case (code)
            OP_ADD:    ;
            OP_SUB:    c.is_sub = 1'b1;
            OP_ADDU_S: c.clamp = CL_UNS;
            OP_ADDS_S: c.clamp = CL_SGN;
            OP_SUBU_S: begin c.is_sub = 1'b1; c.clamp = CL_UNS; end
            OP_SUBS_S: begin c.is_sub = 1'b1; c.clamp = CL_SGN; end
            OP_AND:    begin c.src = RS_LOGIC; c.logic_fn = 2'd0; end
            OP_OR:     begin c.src = RS_LOGIC; c.logic_fn = 2'd1; end
            OP_XOR:    begin c.src = RS_LOGIC; c.logic_fn = 2'd2; end
            default:   c.src = RS_ZERO;
        endcase
        return c;
    endfunction

    function automatic int slices_per_lane(input logic [1:0] mode);
        case (mode)
            LM_WORD:  return 2;
            LM_DWORD: return 4;
            default:  return 1;
        endcase
    endfunction

endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map
    import simd_pkg::*;
(
    input  logic [1:0]  lane_mode,
    output slice_pos_t  pos [N_SLICE]
);
    logic [IDX_W-1:0] span_m1;

    always_comb begin
        span_m1 = IDX_W'(slices_per_lane(lane_mode) - 1);
    end

    for (genvar k = 0; k < N_SLICE; k++) begin : g_pos
        localparam logic [IDX_W-1:0] KI = IDX_W'(k);
        always_comb begin
            pos[k].bottom  = ((KI & span_m1) == '0);
            pos[k].top     = ((KI & span_m1) == span_m1);
            pos[k].top_idx = KI | span_m1;
        end
    end
endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
    import simd_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_sub,
    input  slice_pos_t        pos [N_SLICE],
    output logic [DATA_W-1:0] b_eff,
    output logic [DATA_W-1:0] sum,
    output logic [N_SLICE-1:0] cout
);
    logic [N_SLICE-1:0] cin;

    assign b_eff = is_sub ? ~b : b;

    for (genvar k = 0; k < N_SLICE; k++) begin : g_slice
        logic [SLICE_W:0] s_ext;
        if (k == 0) begin : g_first
            assign cin[k] = is_sub;
        end else begin : g_chain
            assign cin[k] = pos[k].bottom ? is_sub : cout[k-1];
        end
        always_comb begin
            s_ext = {1'b0, a[k*SLICE_W +: SLICE_W]}
                  + {1'b0, b_eff[k*SLICE_W +: SLICE_W]}
                  + {{SLICE_W{1'b0}}, cin[k]};
        end
        assign sum[k*SLICE_W +: SLICE_W] = s_ext[SLICE_W-1:0];
        assign cout[k] = s_ext[SLICE_W];
    end
endmodule

// File: rtl/simd_clamp_sel.sv
module simd_clamp_sel
    import simd_pkg::*;
(
    input  op_ctl_t           ctl,
    input  slice_pos_t        pos [N_SLICE],
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] b_eff,
    input  logic [DATA_W-1:0] sum,
    input  logic [N_SLICE-1:0] cout,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] logic_y;

    always_comb begin
        case (ctl.logic_fn)
            2'd1:    logic_y = a | b;
            2'd2:    logic_y = a ^ b;
            default: logic_y = a & b;
        endcase
    end

    for (genvar k = 0; k < N_SLICE; k++) begin : g_sel
        logic             lane_c;
        logic             a_top, b_top, s_top;
        logic             sgn_ovf, uns_ovf, neg;
        logic [SLICE_W-1:0] arith, sat_val;
        logic [IDX_W-1:0] t;

        always_comb begin
            t      = pos[k].top_idx;
            lane_c = cout[t];
            a_top  = a[{t, 3'd7}];
            b_top  = b_eff[{t, 3'd7}];
            s_top  = sum[{t, 3'd7}];
            sgn_ovf = (a_top == b_top) && (s_top != a_top);
            uns_ovf = ctl.is_sub ? ~lane_c : lane_c;
            neg     = a_top;
            arith   = sum[k*SLICE_W +: SLICE_W];
            sat_val = '0;
            case (ctl.clamp)
                CL_UNS: begin
                    sat_val = ctl.is_sub ? {SLICE_W{1'b0}} : {SLICE_W{1'b1}};
                    if (uns_ovf) arith = sat_val;
                end
                CL_SGN: begin
                    sat_val = pos[k].top ? {neg, {(SLICE_W-1){~neg}}}
                                         : {SLICE_W{~neg}};
                    if (sgn_ovf) arith = sat_val;
                end
                default: ;
            endcase
            case (ctl.src)
                RS_LOGIC: y[k*SLICE_W +: SLICE_W] = logic_y[k*SLICE_W +: SLICE_W];
                RS_ZERO:  y[k*SLICE_W +: SLICE_W] = '0;
                default:  y[k*SLICE_W +: SLICE_W] = arith;
            endcase
        end
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [3:0]        op_code,
    input  logic [1:0]        lane_mode,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    op_ctl_t            ctl;
    slice_pos_t         pos [N_SLICE];
    logic [DATA_W-1:0]  b_eff, sum, y;
    logic [N_SLICE-1:0] cout;

    assign ctl = decode_op(op_code);

    simd_lane_map u_map (
        .lane_mode (lane_mode),
        .pos       (pos)
    );

    simd_seg_adder u_add (
        .a      (op_a),
        .b      (op_b),
        .is_sub (ctl.is_sub),
        .pos    (pos),
        .b_eff  (b_eff),
        .sum    (sum),
        .cout   (cout)
    );

    simd_clamp_sel u_sel (
        .ctl   (ctl),
        .pos   (pos),
        .a     (op_a),
        .b     (op_b),
        .b_eff (b_eff),
        .sum   (sum),
        .cout  (cout),
        .y     (y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) res_data <= y;
        end
    end
endmodule

// File: rtl/simd_alu_checker.sv
module simd_alu_checker
    import simd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [3:0]        op_code,
    input logic [1:0]        lane_mode,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!res_valid && res_data == '0));

    // R2
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    // R2
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && $stable(res_data)));

    // R3
    a_r3_add_zero_identity: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'd0 && op_b == '0) |=> res_data == $past(op_a));

    // R8
    a_r8_and_lanes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'd6) |=> res_data == ($past(op_a) & $past(op_b)));

    // R9
    a_r9_bad_op_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code > 4'd8) |=> res_data == '0);

    // R6
    a_r6_self_sub_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'd4 && op_a == op_b) |=> res_data == '0);
endmodule

bind simd_alu simd_alu_checker u_chk (.*);

// File: tb/simd_alu_bench.sv
module simd_alu_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [3:0]  op_code = '0;
    logic [1:0]  lane_mode = '0;
    logic        res_valid;
    logic [63:0] res_data;

    int n_vec = 0;
    int n_bad = 0;
    logic        exp_valid = 1'b0;
    logic [63:0] exp_data = '0;
    string       exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_alu u_simd_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .op_code(op_code), .lane_mode(lane_mode),
        .res_valid(res_valid), .res_data(res_data)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd4: return "R6";
            4'd3, 4'd5: return "R7";
            4'd6, 4'd7, 4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [3:0] op, input logic [1:0] md);
        logic [63:0] r = '0;
        int w = (md == 2'd1) ? 16 : (md == 2'd2) ? 32 : 8;
        longint full = longint'(1) << w;
        longint half = full >> 1;
        if (op == 4'd6) return a & b;
        if (op == 4'd7) return a | b;
        if (op == 4'd8) return a ^ b;
        if (op > 4'd8)  return '0;
        for (int l = 0; l < 64 / w; l++) begin
            longint ua = longint'((a >> (l*w)) & 64'(full - 1));
            longint ub = longint'((b >> (l*w)) & 64'(full - 1));
            longint sa = (ua >= half) ? ua - full : ua;
            longint sb = (ub >= half) ? ub - full : ub;
            longint v;
            case (op)
                4'd0: v = ua + ub;
                4'd1: v = ua - ub;
                4'd2: begin v = ua + ub; if (v > full - 1) v = full - 1; end
                4'd4: begin v = ua - ub; if (v < 0) v = 0; end
                4'd3: begin v = sa + sb; if (v > half-1) v = half-1; if (v < -half) v = -half; end
                default: begin v = sa - sb; if (v > half-1) v = half-1; if (v < -half) v = -half; end
            endcase
            r = r | ((64'(v) & 64'(full - 1)) << (l*w));
        end
        return r;
    endfunction

    task automatic compare();
        n_vec++;
        if (res_valid !== exp_valid) begin
            n_bad++;
            $display("FAIL R2 res_valid actual=%0b expected=%0b", res_valid, exp_valid);
        end else if (res_data !== exp_data) begin
            n_bad++;
            $display("FAIL %s res_data actual=%h expected=%h", exp_tag, res_data, exp_data);
        end
    endtask

    task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                        input logic [3:0] op, input logic [1:0] md);
        @(negedge clk);
        compare();
        in_valid = v; op_a = a; op_b = b; op_code = op; lane_mode = md;
        exp_valid = v;
        if (v) begin
            exp_data = model(a, b, op, md);
            exp_tag  = tag_of(op);
        end else begin
            exp_tag = "R2";
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare();                 // R1 during reset
        rst = 1'b0;
        step(0, '0, '0, 0, 0);     // R1 first cycle after reset
        // R3 R10: carry blocked at each lane size
        step(1, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 0, 0);
        step(1, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 0, 1);
        step(1, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 0, 1);
        step(1, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 0, 2);
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 2);
        step(1, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 0, 3);
        step(1, 64'h0706_0504_0302_0100, 64'h1010_1010_1010_1010, 0, 0);
        // R4 borrow blocked
        step(1, 64'h0100_0100_0100_0100, 64'h0001_0001_0001_0001, 1, 0);
        step(1, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 1, 2);
        // R5 R6 unsigned clamps
        step(1, 64'hFFF0_FF80_0001_7FFF, 64'h0020_0080_0001_0001, 2, 0);
        step(1, 64'hFFF0_FF80_0001_7FFF, 64'h0020_0080_0001_0001, 2, 1);
        step(1, 64'h0010_0000_8000_0005, 64'h0020_0001_7FFF_0003, 4, 0);
        step(1, 64'h0010_0000_8000_0005, 64'h0020_0001_7FFF_0003, 4, 1);
        // R7 signed clamps
        step(1, 64'h7F80_7F80_7FFF_8000, 64'h0180_0101_0001_FFFF, 3, 0);
        step(1, 64'h7F80_7F80_7FFF_8000, 64'h0180_0101_0001_FFFF, 3, 1);
        step(1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001, 3, 2);
        step(1, 64'h807F_807F_8000_7FFF, 64'h01FF_7F80_0001_FFFF, 5, 0);
        step(1, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 5, 2);
        // R8 logic, mode ignored
        step(1, 64'hF0F0_1234_AAAA_5555, 64'hFF00_4321_5555_FFFF, 6, 2);
        step(1, 64'hF0F0_1234_AAAA_5555, 64'hFF00_4321_5555_FFFF, 7, 0);
        step(1, 64'hF0F0_1234_AAAA_5555, 64'hFF00_4321_5555_FFFF, 8, 1);
        // R9 undefined opcodes
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 9, 0);
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 15, 2);
        // R2 hold across idle cycles with changing inputs
        step(1, 64'h1111_2222_3333_4444, 64'h0101_0101_0101_0101, 0, 0);
        step(0, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1, 0, 0);
        step(0, 64'h0, 64'h0, 6, 1);
        // random sweep
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            step(r[0] | r[1], {$urandom, $urandom}, {$urandom, $urandom},
                 (r[7:4] > 4'd10) ? 4'(r[9:8] + 9) : 4'(r[7:4] % 9), r[11:10]);
        end
        step(0, '0, '0, 0, 0);
        @(negedge clk);
        compare();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule